// File: doc/BRIEF.md
# Red-eye strobe sequencer

This block drives a camera flash line for red-eye reduction. A capture-start trigger launches a fixed sequence. First comes a train of short pre-strobe pulses, which make the subject's pupils contract. The main flash pulse follows. Every delay and width is counted in ticks of a slow counter clock. That clock reaches the block as a one-cycle enable pulse in the system clock domain.

Five setting inputs configure the sequence. A packed 32-bit word carries the spacing between pre-strobe pulses in bits [24:0] and the number of extra pulses in bits [31:25]. The other four inputs set the delay to the first pre-strobe, the pre-strobe width, the delay from the last pre-strobe to the main flash, and the main flash width. All settings are captured when the trigger is accepted, so software may rewrite them while a sequence is running.

The state machine has six states:

| State | Meaning | Leaves on the ending tick for |
|---|---|---|
| IDLE | Waiting for a trigger | WAIT_FIRST, when trigger and enable are both high (start) |
| WAIT_FIRST | Delay before the first pre-strobe | PRE_ON |
| PRE_ON | A pre-strobe pulse is high | PRE_GAP if pulses remain, otherwise WAIT_MAIN |
| PRE_GAP | Low gap between pre-strobe pulses | PRE_ON |
| WAIT_MAIN | Delay before the main flash | MAIN_ON |
| MAIN_ON | The main flash is high | IDLE |

Dropping the enable input sends the machine from any state straight to IDLE.

Top module: `redeye_strobe`

## Requirements
- R1: After reset the strobe output is low and the machine is in IDLE.
- R2: A trigger sampled high in IDLE while enable is high starts a sequence. The first pre-strobe goes high after the counter tick numbered first_dly+1, counting ticks after the trigger edge.
- R3: Each pre-strobe pulse stays high for exactly pre_width+1 counter ticks.
- R4: Bits [31:25] of rep_word give the number of extra pre-strobe pulses, so the train has that value plus one pulses in total. A value of 2 gives three pulses and 0 gives one.
- R5: Bits [24:0] of rep_word set the low gap between pre-strobe pulses to that value plus one ticks. A value of 0 starts the next pulse on the first tick after the previous one ends.
- R6: After the last pre-strobe ends, the output stays low for main_dly+1 ticks. It is then high for main_width+1 ticks and returns low, with the machine back in IDLE.
- R7: The strobe output is the OR of the pre-strobe phase and the main flash phase. The two phases never overlap.
- R8: Sequence timing advances only on cycles where cnt_tick is high. Without ticks the state and output hold.
- R9: A trigger is ignored while a sequence is active. A trigger is also ignored while enable is low.
- R10: With enable low the output is low in the same cycle and the machine is in IDLE from the next edge. Raising enable again does not resume the sequence.
- R11: Setting inputs are captured at the accepted trigger. Changes made during a sequence do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_tick | input | 1 | One-cycle pulse per counter-clock period |
| trig | input | 1 | Capture-start trigger |
| en | input | 1 | Block enable |
| rep_word | input | 32 | [24:0] gap between pre-strobes, [31:25] extra pulse count |
| first_dly | input | 16 | Ticks before the first pre-strobe, minus one |
| pre_width | input | 16 | Pre-strobe width in ticks, minus one |
| main_dly | input | 16 | Ticks from the last pre-strobe to the main flash, minus one |
| main_width | input | 16 | Main flash width in ticks, minus one |
| strobe | output | 1 | Flash control output |

## Verification
The assertions assume that cnt_tick is a single-cycle pulse and that the trigger is level-sampled on system clock edges. The bench keeps ticks at one cycle in every three. It never raises the trigger and a tick in the same cycle while the machine is in IDLE, so every accepted start loads its first delay without a tick being lost. Disabling is applied at a falling clock edge, which lets the same-cycle drop of the output be observed before the next rising edge.

// File: rtl/rstrobe_pkg.sv
package rstrobe_pkg;
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_WAIT_FIRST = 3'd1,
        ST_PRE_ON     = 3'd2,
        ST_PRE_GAP    = 3'd3,
        ST_WAIT_MAIN  = 3'd4,
        ST_MAIN_ON    = 3'd5
    } rs_state_e;
endpackage

// File: rtl/rstrobe_cfg_latch.sv
module rstrobe_cfg_latch #(
    parameter int DLY_W  = 25,
    parameter int REP_W  = 7,
    parameter int TIME_W = 16,
    localparam int WORD_W = DLY_W + REP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [WORD_W-1:0] rep_word,
    input  logic [TIME_W-1:0] pre_width,
    input  logic [TIME_W-1:0] main_dly,
    input  logic [TIME_W-1:0] main_width,
    output logic [DLY_W-1:0]  gap_q,
    output logic [REP_W-1:0]  rep_q,
    output logic [TIME_W-1:0] pre_width_q,
    output logic [TIME_W-1:0] main_dly_q,
    output logic [TIME_W-1:0] main_width_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q        <= '0;
            rep_q        <= '0;
            pre_width_q  <= '0;
            main_dly_q   <= '0;
            main_width_q <= '0;
        end else if (capture) begin
            gap_q        <= rep_word[DLY_W-1:0];
            rep_q        <= rep_word[WORD_W-1:DLY_W];
            pre_width_q  <= pre_width;
            main_dly_q   <= main_dly;
            main_width_q <= main_width;
        end
    end
endmodule

// File: rtl/rstrobe_timer.sv
module rstrobe_timer #(
    parameter int CNT_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/rstrobe_fsm.sv
module rstrobe_fsm
    import rstrobe_pkg::*;
#(
    parameter int DLY_W  = 25,
    parameter int REP_W  = 7,
    parameter int TIME_W = 16,
    localparam int CNT_W = (DLY_W > TIME_W) ? DLY_W : TIME_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              trig,
    input  logic              tick,
    input  logic              tmr_zero,
    input  logic [TIME_W-1:0] first_dly_raw,
    input  logic [REP_W-1:0]  rep_raw,
    input  logic [DLY_W-1:0]  gap_q,
    input  logic [TIME_W-1:0] pre_width_q,
    input  logic [TIME_W-1:0] main_dly_q,
    input  logic [TIME_W-1:0] main_width_q,
    output logic              start,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              pre_sig,
    output logic              main_sig,
    output rs_state_e         state,
    output logic [REP_W-1:0]  pulses_left
);
    rs_state_e state_q, state_d;
    logic      phase_end;
    logic      rem_dec;

    assign start     = (state_q == ST_IDLE) && trig && en;
    assign phase_end = tick && tmr_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        rem_dec  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d  = ST_WAIT_FIRST;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(first_dly_raw);
                end
            end
            ST_WAIT_FIRST: begin
                if (phase_end) begin
                    state_d  = ST_PRE_ON;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(pre_width_q);
                end
            end
            ST_PRE_ON: begin
                if (phase_end) begin
                    tmr_load = 1'b1;
                    if (pulses_left == '0) begin
                        state_d = ST_WAIT_MAIN;
                        tmr_val = CNT_W'(main_dly_q);
                    end else begin
                        state_d = ST_PRE_GAP;
                        tmr_val = CNT_W'(gap_q);
                    end
                end
            end
            ST_PRE_GAP: begin
                if (phase_end) begin
                    state_d  = ST_PRE_ON;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(pre_width_q);
                    rem_dec  = 1'b1;
                end
            end
            ST_WAIT_MAIN: begin
                if (phase_end) begin
                    state_d  = ST_MAIN_ON;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(main_width_q);
                end
            end
            ST_MAIN_ON: begin
                if (phase_end) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (!en) begin
            state_d  = ST_IDLE;
            tmr_load = 1'b0;
            rem_dec  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulses_left <= '0;
        end else if (start) begin
            pulses_left <= rep_raw;
        end else if (rem_dec) begin
            pulses_left <= pulses_left - 1'b1;
        end
    end

    always_comb begin
        pre_sig  = (state_q == ST_PRE_ON);
        main_sig = (state_q == ST_MAIN_ON);
    end

    assign state = state_q;
endmodule

// File: rtl/redeye_strobe.sv
module redeye_strobe
    import rstrobe_pkg::*;
#(
    parameter int DLY_W  = 25,
    parameter int REP_W  = 7,
    parameter int TIME_W = 16,
    localparam int WORD_W = DLY_W + REP_W,
    localparam int CNT_W  = (DLY_W > TIME_W) ? DLY_W : TIME_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_tick,
    input  logic              trig,
    input  logic              en,
    input  logic [WORD_W-1:0] rep_word,
    input  logic [TIME_W-1:0] first_dly,
    input  logic [TIME_W-1:0] pre_width,
    input  logic [TIME_W-1:0] main_dly,
    input  logic [TIME_W-1:0] main_width,
    output logic              strobe
);
    logic              start;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              pre_sig;
    logic              main_sig;
    rs_state_e         fsm_state;
    logic [REP_W-1:0]  pulses_left;
    logic [DLY_W-1:0]  gap_q;
    logic [REP_W-1:0]  rep_q;
    logic [TIME_W-1:0] pre_width_q;
    logic [TIME_W-1:0] main_dly_q;
    logic [TIME_W-1:0] main_width_q;

    rstrobe_cfg_latch #(
        .DLY_W (DLY_W),
        .REP_W (REP_W),
        .TIME_W(TIME_W)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (start),
        .rep_word    (rep_word),
        .pre_width   (pre_width),
        .main_dly    (main_dly),
        .main_width  (main_width),
        .gap_q       (gap_q),
        .rep_q       (rep_q),
        .pre_width_q (pre_width_q),
        .main_dly_q  (main_dly_q),
        .main_width_q(main_width_q)
    );

    rstrobe_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .tick    (cnt_tick),
        .zero    (tmr_zero)
    );

    rstrobe_fsm #(
        .DLY_W (DLY_W),
        .REP_W (REP_W),
        .TIME_W(TIME_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .trig         (trig),
        .tick         (cnt_tick),
        .tmr_zero     (tmr_zero),
        .first_dly_raw(first_dly),
        .rep_raw      (rep_word[WORD_W-1:DLY_W]),
        .gap_q        (gap_q),
        .pre_width_q  (pre_width_q),
        .main_dly_q   (main_dly_q),
        .main_width_q (main_width_q),
        .start        (start),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .pre_sig      (pre_sig),
        .main_sig     (main_sig),
        .state        (fsm_state),
        .pulses_left  (pulses_left)
    );

    assign strobe = en & (pre_sig | main_sig);
endmodule

// File: rtl/rstrobe_chk.sv
module rstrobe_chk
    import rstrobe_pkg::*;
#(
    parameter int REP_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             trig,
    input logic             cnt_tick,
    input logic             strobe,
    input logic             pre_sig,
    input logic             main_sig,
    input rs_state_e        state,
    input logic [REP_W-1:0] pulses_left,
    input logic [REP_W-1:0] rep_q
);
    AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> state == ST_IDLE); // R1

    AST_START_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && trig && en) |=> state == ST_WAIT_FIRST); // R2

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> pulses_left <= rep_q); // R4

    AST_MAIN_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_MAIN_ON) |-> $past(state) == ST_WAIT_MAIN); // R6

    AST_PHASES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pre_sig, main_sig})); // R7

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_tick && en && state != ST_IDLE) |=> $stable(state)); // R8

    AST_DISABLE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_IDLE && !strobe) || en); // R10
endmodule

bind redeye_strobe rstrobe_chk #(.REP_W(REP_W)) u_rstrobe_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .trig       (trig),
    .cnt_tick   (cnt_tick),
    .strobe     (strobe),
    .pre_sig    (pre_sig),
    .main_sig   (main_sig),
    .state      (fsm_state),
    .pulses_left(pulses_left),
    .rep_q      (rep_q)
);

// File: tb/test_redeye_strobe.sv
module test_redeye_strobe;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_tick = 1'b0;
    logic        trig = 1'b0;
    logic        en = 1'b0;
    logic [31:0] rep_word = '0;
    logic [15:0] first_dly = '0;
    logic [15:0] pre_width = '0;
    logic [15:0] main_dly = '0;
    logic [15:0] main_width = '0;
    logic        strobe;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    redeye_strobe i_redeye_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_tick  (cnt_tick),
        .trig      (trig),
        .en        (en),
        .rep_word  (rep_word),
        .first_dly (first_dly),
        .pre_width (pre_width),
        .main_dly  (main_dly),
        .main_width(main_width),
        .strobe    (strobe)
    );

    task automatic check(input string req, input logic act, input logic exp, input int at);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s tick %0d: strobe actual %0b expected %0b", req, at, act, exp);
        end
    endtask

    // Expected strobe after tick k counted from the trigger edge (R2 R3 R4 R5 R6)
    function automatic logic expect_at(int k, int f, int p, int g, int r, int m, int w);
        int pos = f + 1;
        if (k < pos) return 1'b0;
        for (int i = 0; i <= r; i++) begin
            if (k < pos + p + 1) return 1'b1;
            pos += p + 1;
            if (i < r) begin
                if (k < pos + g + 1) return 1'b0;
                pos += g + 1;
            end
        end
        if (k < pos + m + 1) return 1'b0;
        pos += m + 1;
        if (k < pos + w + 1) return 1'b1;
        return 1'b0;
    endfunction

    task automatic set_cfg(int f, int p, int g, int r, int m, int w);
        rep_word   = {r[6:0], g[24:0]};
        first_dly  = f[15:0];
        pre_width  = p[15:0];
        main_dly   = m[15:0];
        main_width = w[15:0];
    endtask

    // Runs one triggered sequence and compares every cycle with the expected waveform.
    task automatic run_seq(string req, int f, int p, int g, int r, int m, int w,
                           int retrig_cyc, int chg_cyc);
        int nt = 0;
        int last;
        set_cfg(f, p, g, r, m, w);
        @(negedge clk);
        cnt_tick = 1'b0;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        last = (f + 1) + (r + 1) * (p + 1) + r * (g + 1) + (m + 1) + (w + 1) + 3;
        for (int cyc = 0; nt <= last; cyc++) begin
            if (cyc > 0) @(negedge clk);
            check(req, strobe, expect_at(nt, f, p, g, r, m, w), nt);
            trig = (cyc == retrig_cyc);
            if (cyc == chg_cyc) set_cfg(0, 0, 0, 0, 0, 0);
            cnt_tick = ((cyc % TICK_DIV) == TICK_DIV - 1);
            if (cnt_tick) nt++;
        end
        @(negedge clk);
        cnt_tick = 1'b0;
        trig = 1'b0;
        check(req, strobe, 1'b0, nt);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 reset low", strobe, 1'b0, 0);
        en = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle after reset", strobe, 1'b0, 0);
    endtask

    task automatic t_three_pulses;
        // R4: repeat 2 gives three pre-strobes; R3 R5 R6 R7 R8 widths and spacing
        run_seq("R4 R3 R6 R7 R8", 2, 1, 2, 2, 3, 4, -1, -1);
    endtask

    task automatic t_single_pulse;
        run_seq("R4 single R2 R6", 0, 0, 5, 0, 0, 0, -1, -1);
    endtask

    task automatic t_gap_zero;
        run_seq("R5 gap zero", 1, 2, 0, 3, 1, 1, -1, -1);
    endtask

    task automatic t_retrigger;
        run_seq("R9 retrigger ignored", 3, 1, 1, 1, 1, 2, 7, -1);
    endtask

    task automatic t_cfg_change;
        run_seq("R11 settings captured", 2, 3, 1, 2, 2, 2, -1, 2);
    endtask

    task automatic t_disable;
        int nt = 0;
        set_cfg(0, 8, 0, 0, 0, 0);
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        for (int cyc = 0; nt < 3; cyc++) begin
            cnt_tick = ((cyc % TICK_DIV) == TICK_DIV - 1);
            if (cnt_tick) nt++;
            @(negedge clk);
        end
        cnt_tick = 1'b0;
        check("R10 high before disable", strobe, 1'b1, nt);
        en = 1'b0;
        #1;
        check("R10 low at once", strobe, 1'b0, nt);
        for (int cyc = 0; cyc < 6; cyc++) begin
            @(negedge clk);
            cnt_tick = ((cyc % TICK_DIV) == TICK_DIV - 1);
            check("R10 low while disabled", strobe, 1'b0, nt);
        end
        en = 1'b1;
        for (int cyc = 0; cyc < 60; cyc++) begin
            @(negedge clk);
            cnt_tick = ((cyc % TICK_DIV) == TICK_DIV - 1);
            check("R10 no resume", strobe, 1'b0, nt);
        end
        cnt_tick = 1'b0;
    endtask

    task automatic t_trig_disabled;
        set_cfg(0, 2, 0, 0, 0, 2);
        @(negedge clk);
        en = 1'b0;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        en = 1'b1;
        for (int cyc = 0; cyc < 45; cyc++) begin
            @(negedge clk);
            cnt_tick = ((cyc % TICK_DIV) == TICK_DIV - 1);
            check("R9 trigger while disabled", strobe, 1'b0, cyc);
        end
        cnt_tick = 1'b0;
        run_seq("R9 start after enable", 0, 2, 0, 0, 0, 2, -1, -1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_three_pulses();
        t_single_pulse();
        t_gap_zero();
        t_retrigger();
        t_cfg_change();
        t_disable();
        t_trig_disabled();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule